// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block keeps a small set of recent virtual-to-physical page translations so that a core can turn a virtual address into a physical one without going to the page tables each time. Every entry carries a valid flag, read, write, execute and dirty permission bits, a virtual page tag and a physical page number. Any translation can sit in any entry. A lookup is combinational on the stored state, so hit, physical address and permission bits come back in the same cycle as the request.

When a lookup misses, the block raises a walk request for an external table walker. The walker answers with a fill that carries the page tag, the physical page number and the permission bits. The core retries the lookup after the fill. A write that hits an entry whose dirty bit is clear is reported as a miss, so that the walker can set the dirty bit in memory and then refill the entry. The block never writes any entry back to memory. A write to the page-table base register clears every entry. Software can drop the single entry for one virtual page after it has edited the tables.

Top module: `tlb_fa`

## Requirements
- R1: When `lk_valid` is high and a valid entry's tag equals `lk_vaddr[31:12]`, the same cycle shows `lk_hit` high, `lk_paddr = {ppn, lk_vaddr[11:0]}` and `lk_perm` = the stored bits, with bit 0 read, bit 1 write, bit 2 execute and bit 3 dirty.
- R2: `lk_walk_req` is high exactly when `lk_valid` is high and `lk_hit` is low. It is low whenever `lk_valid` is low.
- R3: Access type encoding: 00 read, 01 write, 10 execute. A write to a matching entry whose dirty bit is 0 gives a miss and a walk request. Read and execute lookups to that same entry hit.
- R4: An entry installed by `fill_valid` can be looked up from the next cycle on.
- R5: A fill whose tag is already present replaces that entry, so the tag never matches two entries.
- R6: A fill goes to the lowest-numbered invalid entry if there is one. Otherwise it replaces the least recently used entry. Hits and fills both count as uses. Misses do not.
- R7: A cycle with `base_wr` high invalidates every entry. A fill or hit in that same cycle has no effect.
- R8: `inv_valid` invalidates only the entry whose tag equals `inv_vpn`. Other entries are untouched, and a page that is not present causes no change.
- R9: When an invalidate and a fill name the same page in one cycle, the filled translation remains installed.
- R10: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_acc | input | 2 | Access type: 00 read, 01 write, 10 execute |
| lk_hit | output | 1 | Translation found and usable |
| lk_walk_req | output | 1 | Miss: table walk requested |
| lk_paddr | output | 32 | Translated physical address (valid on hit) |
| lk_perm | output | 4 | {dirty, execute, write, read} of the hit entry |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page tag to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_perm | input | 4 | {dirty, execute, write, read} to install |
| base_wr | input | 1 | Page-table base register write: flush all |
| inv_valid | input | 1 | Invalidate one page |
| inv_vpn | input | 20 | Virtual page to invalidate |

## Verification
If a valid bit is wrong, it shows up on the next lookup of that page as a hit that should miss, or a miss that should hit. A corrupted tag or page number gives a wrong `lk_paddr` in the same cycle the page is looked up. Faults in the recency state stay hidden until the buffer is full and a fill has to evict something. For that reason the bench fills every entry, reorders the entries with hits, and then checks which page the next fill removed. Duplicate tags and a recency order that stops being a permutation are caught internally on the cycle they appear, well before any port would show them.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_vaddr,
  input  logic [1:0]            lk_acc,
  output logic                  lk_hit,
  output logic                  lk_walk_req,
  output logic [PA_W-1:0]       lk_paddr,
  output logic [3:0]            lk_perm,
  input  logic                  fill_valid,
  input  logic [VA_W-OFF_W-1:0] fill_vpn,
  input  logic [PA_W-OFF_W-1:0] fill_ppn,
  input  logic [3:0]            fill_perm,
  input  logic                  base_wr,
  input  logic                  inv_valid,
  input  logic [VA_W-OFF_W-1:0] inv_vpn
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int AW    = $clog2(ENTRIES);
  localparam logic [AW-1:0] OLDEST = AW'(ENTRIES - 1);

  logic [ENTRIES-1:0]          vld;
  logic [ENTRIES-1:0][VPN_W-1:0] tag;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn;
  logic [ENTRIES-1:0][3:0]     prm;
  logic [ENTRIES-1:0][AW-1:0]  age;

  logic [ENTRIES-1:0] lk_match, fl_match, inv_match;
  logic [AW-1:0] lk_idx, fl_idx, free_idx, lru_idx, put_idx, touch_idx;
  logic          lk_any, fl_any, free_any, wr_clean, touch_en;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign lk_match[i]  = vld[i] && (tag[i] == lk_vaddr[VA_W-1:OFF_W]);
    assign fl_match[i]  = vld[i] && (tag[i] == fill_vpn);
    assign inv_match[i] = vld[i] && (tag[i] == inv_vpn);
  end

  always_comb begin
    lk_idx = '0; fl_idx = '0; free_idx = '0; lru_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lk_match[i]) lk_idx = AW'(i);
      if (fl_match[i]) fl_idx = AW'(i);
      if (!vld[i]) free_idx = AW'(i);
      if (age[i] == OLDEST) lru_idx = AW'(i);
    end
  end

  assign lk_any   = |lk_match;
  assign fl_any   = |fl_match;
  assign free_any = ~&vld;
  assign put_idx  = fl_any ? fl_idx : (free_any ? free_idx : lru_idx);

  assign wr_clean    = (lk_acc == 2'b01) && !prm[lk_idx][3];
  assign lk_hit      = lk_valid && lk_any && !wr_clean;
  assign lk_walk_req = lk_valid && !lk_hit;
  assign lk_paddr    = {ppn[lk_idx], lk_vaddr[OFF_W-1:0]};
  assign lk_perm     = lk_any ? prm[lk_idx] : 4'b0000;

  assign touch_en  = !base_wr && (fill_valid || lk_hit);
  assign touch_idx = fill_valid ? put_idx : lk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      tag <= '0;
      ppn <= '0;
      prm <= '0;
      for (int i = 0; i < ENTRIES; i++) age[i] <= AW'(i);
    end else if (base_wr) begin
      vld <= '0;
    end else begin
      if (inv_valid) vld <= vld & ~inv_match;
      if (fill_valid) begin
        vld[put_idx] <= 1'b1;
        tag[put_idx] <= fill_vpn;
        ppn[put_idx] <= fill_ppn;
        prm[put_idx] <= fill_perm;
      end
      if (touch_en)
        for (int i = 0; i < ENTRIES; i++) begin
          if (AW'(i) == touch_idx) age[i] <= '0;
          else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
        end
    end
  end
endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
  parameter int ENTRIES = 16,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int AW      = $clog2(ENTRIES)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_valid,
  input logic [VA_W-1:0]            lk_vaddr,
  input logic [1:0]                 lk_acc,
  input logic                       lk_hit,
  input logic                       lk_walk_req,
  input logic [PA_W-1:0]            lk_paddr,
  input logic [3:0]                 lk_perm,
  input logic                       base_wr,
  input logic [ENTRIES-1:0]         vld,
  input logic [ENTRIES-1:0]         lk_match,
  input logic [ENTRIES-1:0][AW-1:0] age
);
  int oldest_cnt;
  always_comb begin
    oldest_cnt = 0;
    for (int i = 0; i < ENTRIES; i++)
      if (age[i] == AW'(ENTRIES - 1)) oldest_cnt++;
  end

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]);
  // R2
  walk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_walk_req |-> lk_valid && !lk_hit);
  // R2
  walk_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> lk_walk_req);
  // R3
  dirty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_acc == 2'b01) |-> lk_perm[3]);
  // R5
  no_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  // R6
  one_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oldest_cnt == 1);
  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> vld == '0);
endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
  .lk_hit(lk_hit), .lk_walk_req(lk_walk_req), .lk_paddr(lk_paddr), .lk_perm(lk_perm),
  .base_wr(base_wr), .vld(vld), .lk_match(lk_match), .age(age)
);

// File: tb/sim_tlb_fa.sv
module sim_tlb_fa;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [1:0]  lk_acc = '0;
  logic        lk_hit, lk_walk_req;
  logic [31:0] lk_paddr;
  logic [3:0]  lk_perm;
  logic        fill_valid = 1'b0;
  logic [19:0] fill_vpn = '0, fill_ppn = '0;
  logic [3:0]  fill_perm = '0;
  logic        base_wr = 1'b0;
  logic        inv_valid = 1'b0;
  logic [19:0] inv_vpn = '0;

  int checks = 0, errors = 0;

  typedef struct packed {
    logic        hit;
    logic [31:0] pa;
    logic [3:0]  perm;
    logic [7:0]  req;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  tlb_fa u0 (.*);

  task automatic drive(input logic lv, input logic [31:0] va, input logic [1:0] acc,
                       input logic fv, input logic [19:0] fvpn, input logic [19:0] fppn,
                       input logic [3:0] fperm, input logic iv, input logic [19:0] ivpn,
                       input logic bw);
    @(negedge clk); #1;
    lk_valid = lv; lk_vaddr = va; lk_acc = acc;
    fill_valid = fv; fill_vpn = fvpn; fill_ppn = fppn; fill_perm = fperm;
    inv_valid = iv; inv_vpn = ivpn; base_wr = bw;
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] acc, input logic eh,
                      input logic [19:0] eppn, input logic [3:0] eperm, input int r);
    exp_t e;
    e.hit = eh; e.pa = {eppn, va[11:0]}; e.perm = eperm; e.req = 8'(r);
    sb.push_back(e);
    drive(1'b1, va, acc, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic fill(input logic [19:0] v, input logic [19:0] p, input logic [3:0] pm);
    drive(1'b0, '0, '0, 1'b1, v, p, pm, 1'b0, '0, 1'b0);
  endtask

  task automatic idle();
    drive(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, '0, 1'b0);
  endtask

  // monitor: pop and compare each lookup before the next rising edge
  initial forever begin
    @(negedge clk); #3;
    if (lk_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        errors++; $display("FAIL R2 unexpected lookup: actual queued 0 expected 1");
      end else begin
        e = sb.pop_front();
        checks++;
        if (lk_hit !== e.hit || lk_walk_req !== !e.hit) begin
          errors++;
          $display("FAIL R%0d va=%h hit/walk actual %b/%b expected %b/%b",
                   e.req, lk_vaddr, lk_hit, lk_walk_req, e.hit, !e.hit);
        end else if (e.hit && (lk_paddr !== e.pa || lk_perm !== e.perm)) begin
          errors++;
          $display("FAIL R%0d va=%h pa/perm actual %h/%b expected %h/%b",
                   e.req, lk_vaddr, lk_paddr, lk_perm, e.pa, e.perm);
        end
      end
    end else if (rst_n) begin
      checks++;
      // R2: no walk request without a lookup
      if (lk_walk_req !== 1'b0) begin
        errors++; $display("FAIL R2 idle walk_req actual %b expected 0", lk_walk_req);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R10: empty after reset
    look(32'h0000_1000, 2'b00, 0, '0, '0, 10);
    look(32'h7192_a44c, 2'b01, 0, '0, '0, 10);
    // R1 R4: install and translate
    fill(20'h7192a, 20'h14817, 4'b0011);
    look(32'h7192_a44c, 2'b00, 1, 20'h14817, 4'b0011, 1);
    // R3: clean page, write misses, read and exec hit
    look(32'h7192_a44c, 2'b01, 0, '0, '0, 3);
    look(32'h7192_aff0, 2'b10, 1, 20'h14817, 4'b0011, 3);
    // R5: refill same tag overwrites
    fill(20'h7192a, 20'h14818, 4'b1011);
    look(32'h7192_a44c, 2'b01, 1, 20'h14818, 4'b1011, 5);
    // R8: single-page invalidate
    fill(20'h00042, 20'h00777, 4'b1111);
    drive(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b1, 20'h12345, 1'b0);
    look(32'h7192_a000, 2'b00, 1, 20'h14818, 4'b1011, 8);
    look(32'h0004_2123, 2'b10, 1, 20'h00777, 4'b1111, 8);
    drive(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b1, 20'h7192a, 1'b0);
    look(32'h7192_a000, 2'b00, 0, '0, '0, 8);
    look(32'h0004_2123, 2'b00, 1, 20'h00777, 4'b1111, 8);
    // R9: invalidate and fill of same page in one cycle
    drive(1'b0, '0, '0, 1'b1, 20'h00042, 20'h00888, 4'b0101, 1'b1, 20'h00042, 1'b0);
    look(32'h0004_2abc, 2'b00, 1, 20'h00888, 4'b0101, 9);
    // R7: base write flushes and drops a same-cycle fill
    drive(1'b0, '0, '0, 1'b1, 20'h55555, 20'h0aaaa, 4'b0001, 1'b0, '0, 1'b1);
    look(32'h5555_5000, 2'b00, 0, '0, '0, 7);
    look(32'h0004_2abc, 2'b00, 0, '0, '0, 7);
    // R6: free entries first, then least recently used
    for (int i = 0; i < 16; i++) fill(20'h10000 + 20'(i), 20'h20000 + 20'(i), 4'b0001);
    for (int i = 0; i < 16; i++)
      look({20'h10000 + 20'(i), 12'h008}, 2'b00, 1, 20'h20000 + 20'(i), 4'b0001, 6);
    look(32'h1000_0010, 2'b00, 1, 20'h20000, 4'b0001, 6);
    fill(20'h10010, 20'h20010, 4'b0001);
    look(32'h1000_1010, 2'b00, 0, '0, '0, 6);
    look(32'h1000_0010, 2'b00, 1, 20'h20000, 4'b0001, 6);
    look(32'h1001_0010, 2'b00, 1, 20'h20010, 4'b0001, 6);
    look(32'h1000_f010, 2'b00, 1, 20'h2000f, 4'b0001, 6);
    idle();
    idle();
    if (sb.size() != 0) begin
      errors++; $display("FAIL R2 pending lookups actual %0d expected 0", sb.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule